// File: doc/BRIEF.md
# ADC calibration and digital gain datapath

This block sits behind the decimation filter of a delta-sigma converter. It turns each raw 16-bit conversion word into a corrected output word. The correction runs in two stages. The first stage subtracts the self-calibration offset and multiplies by the self-calibration gain. The second stage subtracts the system offset and multiplies by the system gain. A power-of-two digital gain, with clipping at full scale, is then applied to the corrected value. Each of the four coefficients can be switched out on its own through a byte-wide control register. Switching a coefficient out leaves it stored in the block.

Samples arrive on a valid/data stream and leave on another valid/data stream three cycles later. The block accepts one sample per cycle. The coefficients are loaded through a simple select/data write port. The `bipolar_i` input picks how the words are read: two's complement in bipolar mode, or straight binary in unipolar mode. This choice also sets the limits used for clipping.

Top module: `adc_cal_path`

## Requirements
- R1: After reset, the control byte reads 0x1E. All four coefficients are bypassed and the digital gain is 1, so every output word equals its input word.
- R2: Control byte fields are: bits [7:5] gain code, bit 4 system-gain bypass, bit 3 system-offset bypass, bit 2 self-gain bypass, bit 1 self-offset bypass. Bits [7:1] read back as last written.
- R3: Bit 0 of the control byte is reserved. A write to it has no effect, and it always reads 0.
- R4: The correction order is fixed: y = ((x − self_off) · self_gain) >> 15, then z = ((y − sys_off) · sys_gain) >> 15. Gains are unsigned Q1.15 values. The shift is arithmetic and rounds toward minus infinity.
- R5: A bypassed offset contributes 0. A bypassed gain acts as exactly 0x8000 (1.0). Each bypass bit acts independently of the others.
- R6: Coefficient select codes are: 0 = self offset, 1 = self gain, 2 = system offset, 3 = system gain. Offsets are signed 16-bit values in both modes. After reset the offsets are 0 and the gains are 0x8000.
- R7: The gain code c multiplies the calibrated value by 2^c, for c from 0 to 7. This gain is applied only after both correction stages.
- R8: In bipolar mode, any result outside the 16-bit signed range after a gain multiply or after the digital gain clips to 0x7FFF or 0x8000.
- R9: In unipolar mode, data is unsigned. Any result above 0xFFFF clips to 0xFFFF, and any result below 0 clips to 0x0000.
- R10: A sample presented with `in_valid_i` appears with `out_valid_o` exactly 3 cycles later. The block accepts back-to-back samples. `out_valid_o` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bipolar_i | input | 1 | 1: two's complement data; 0: straight binary data |
| in_valid_i | input | 1 | Raw sample valid |
| in_data_i | input | 16 | Raw conversion word |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 2 | Coefficient select |
| coef_data_i | input | 16 | Coefficient value |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write value |
| ctrl_rdata_o | output | 8 | Control byte read value |
| out_valid_o | output | 1 | Corrected sample valid |
| out_data_o | output | 16 | Corrected, scaled, clipped word |

## Verification
Each pipeline stage reads the mode, the control byte and the coefficients in the cycle it processes a sample. The properties on pass-through and sign preservation therefore assume these inputs stay steady while a sample is in flight. The stimulus meets this assumption by letting the pipeline drain for several idle cycles before it changes the mode, writes a coefficient or rewrites the control byte. Only the sample stream itself runs back to back, with random gaps.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned CODE_W = 3;
  parameter int unsigned N_COEF = 4;
  parameter int unsigned CTRL_W = 8;
  parameter logic [7:0]  CTRL_RST = 8'h1E;

  localparam int unsigned ACC_W  = 2 * DATA_W + 4;
  localparam int unsigned FRAC_W = DATA_W - 1;
  localparam int unsigned SEL_W  = $clog2(N_COEF);
  localparam int unsigned N_STG  = N_COEF / 2;

  typedef logic [DATA_W-1:0]       word_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam word_t UNITY = word_t'(2 ** FRAC_W);
  localparam acc_t  S_MAX = acc_t'(2 ** (DATA_W - 1) - 1);
  localparam acc_t  S_MIN = -acc_t'(2 ** (DATA_W - 1));
  localparam acc_t  U_MAX = acc_t'(2 ** DATA_W - 1);

  function automatic acc_t widen(word_t w, logic bip);
    if (bip) return acc_t'($signed(w));
    return acc_t'($unsigned(w));
  endfunction

  function automatic word_t sat_word(acc_t v, logic bip);
    if (bip) begin
      if (v > S_MAX) return {1'b0, {(DATA_W-1){1'b1}}};
      if (v < S_MIN) return {1'b1, {(DATA_W-1){1'b0}}};
    end else begin
      if (v > U_MAX) return {DATA_W{1'b1}};
      if (v < 0)     return '0;
    end
    return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic [CODE_W-1:0] code_o,
  output logic [N_COEF-1:0] bypass_o
);
  localparam int unsigned CODE_LSB = CTRL_W - CODE_W;

  logic [CTRL_W-1:1] q;
  logic              unused_rsv;

  assign unused_rsv = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= CTRL_RST[CTRL_W-1:1];
    else if (we_i) q <= wdata_i[CTRL_W-1:1];
  end

  // reserved bit 0 is not stored
  assign rdata_o  = {q, 1'b0};
  assign code_o   = q[CTRL_W-1:CODE_LSB];
  assign bypass_o = q[N_COEF:1];

  // R2
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[CTRL_W-1:1] == $past(wdata_i[CTRL_W-1:1]));
endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef
  import adc_cal_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  word_t                        data_i,
  output logic [N_COEF-1:0][DATA_W-1:0] coef_o
);
  for (genvar i = 0; i < N_COEF; i++) begin : g_coef
    // odd slots hold gains, even slots hold offsets
    localparam word_t RST_VAL = (i % 2 == 1) ? UNITY : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  coef_o[i] <= RST_VAL;
      else if (we_i && sel_i == SEL_W'(i))          coef_o[i] <= data_i;
    end
  end

  // R6
  coef_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> coef_o[$past(sel_i)] == $past(data_i));
endmodule

// File: rtl/adc_cal_stage.sv
module adc_cal_stage
  import adc_cal_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bipolar_i,
  input  logic  valid_i,
  input  word_t data_i,
  input  word_t off_i,
  input  word_t gain_i,
  input  logic  off_en_i,
  input  logic  gain_en_i,
  output logic  valid_o,
  output word_t data_o
);
  acc_t  x_w, off_w, gain_w, prod;
  word_t res;

  always_comb begin
    x_w    = widen(data_i, bipolar_i);
    off_w  = off_en_i  ? acc_t'($signed(off_i))    : '0;
    gain_w = gain_en_i ? acc_t'($unsigned(gain_i)) : acc_t'($unsigned(UNITY));
    prod   = (x_w - off_w) * gain_w;
    res    = sat_word(prod >>> FRAC_W, bipolar_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res;
    end
  end

  // R5
  stage_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !off_en_i && !gain_en_i) |=> data_o == $past(data_i));
endmodule

// File: rtl/adc_dgain.sv
module adc_dgain
  import adc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bipolar_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              valid_i,
  input  word_t             data_i,
  output logic              valid_o,
  output word_t             data_o
);
  acc_t  shifted;
  word_t res;

  always_comb begin
    shifted = widen(data_i, bipolar_i) <<< code_i;
    res     = sat_word(shifted, bipolar_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res;
    end
  end

  // R7
  unity_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i == '0) |=> data_o == $past(data_i));

  // R8
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bipolar_i) |=> data_o[DATA_W-1] == $past(data_i[DATA_W-1]));
endmodule

// File: rtl/adc_cal_path.sv
module adc_cal_path
  import adc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bipolar_i,
  input  logic              in_valid_i,
  input  logic [15:0]       in_data_i,
  input  logic              coef_we_i,
  input  logic [1:0]        coef_sel_i,
  input  logic [15:0]       coef_data_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  output logic              out_valid_o,
  output logic [15:0]       out_data_o
);
  logic [CODE_W-1:0]             code_w;
  logic [N_COEF-1:0]             bypass_w;
  logic [N_COEF-1:0][DATA_W-1:0] coef_w;
  logic [N_STG:0]                v_chain;
  logic [N_STG:0][DATA_W-1:0]    d_chain;

  adc_cal_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .rdata_o  (ctrl_rdata_o),
    .code_o   (code_w),
    .bypass_o (bypass_w)
  );

  adc_cal_coef u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we_i),
    .sel_i  (coef_sel_i),
    .data_i (coef_data_i),
    .coef_o (coef_w)
  );

  assign v_chain[0] = in_valid_i;
  assign d_chain[0] = in_data_i;

  // stage 0: self-cal pair, stage 1: system pair
  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    adc_cal_stage u_stg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .bipolar_i (bipolar_i),
      .valid_i   (v_chain[g]),
      .data_i    (d_chain[g]),
      .off_i     (coef_w[2*g]),
      .gain_i    (coef_w[2*g+1]),
      .off_en_i  (!bypass_w[2*g]),
      .gain_en_i (!bypass_w[2*g+1]),
      .valid_o   (v_chain[g+1]),
      .data_o    (d_chain[g+1])
    );
  end

  adc_dgain u_dgain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bipolar_i (bipolar_i),
    .code_i    (code_w),
    .valid_i   (v_chain[N_STG]),
    .data_i    (d_chain[N_STG]),
    .valid_o   (out_valid_o),
    .data_o    (out_data_o)
  );

  // R10
  lat_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##3 out_valid_o);

  // R10
  lat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##3 !out_valid_o);
endmodule

// File: tb/adc_cal_path_bench.sv
`timescale 1ns/1ps
module adc_cal_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bip = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_sel = '0;
  logic [15:0] coef_data = '0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic        out_valid;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  adc_cal_path u_adc_cal_path (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bipolar_i    (bip),
    .in_valid_i   (in_valid),
    .in_data_i    (in_data),
    .coef_we_i    (coef_we),
    .coef_sel_i   (coef_sel),
    .coef_data_i  (coef_data),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .ctrl_rdata_o (ctrl_rdata),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [15:0] cm [4];
  logic [7:0]  ctrl_m = 8'h1E;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [2:0]  vp = '0;
  string       cur_tag = "R1";

  function automatic longint clip(longint v, bit b);
    if (b) begin
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
    end else begin
      if (v > 65535) return 65535;
      if (v < 0)     return 0;
    end
    return v;
  endfunction

  function automatic logic [15:0] ref_out(logic [15:0] x);
    longint v, so, sg, yo, yg;
    v  = bip ? longint'($signed(x)) : longint'(x);
    so = ctrl_m[1] ? 0     : longint'($signed(cm[0]));
    sg = ctrl_m[2] ? 32768 : longint'(cm[1]);
    yo = ctrl_m[3] ? 0     : longint'($signed(cm[2]));
    yg = ctrl_m[4] ? 32768 : longint'(cm[3]);
    v = clip(((v - so) * sg) >>> 15, bip);
    v = clip(((v - yo) * yg) >>> 15, bip);
    v = clip(v * longint'(1 << ctrl_m[7:5]), bip);
    return v[15:0];
  endfunction

  task automatic check_out();
    logic [15:0] e;
    string t;
    n_vec++;
    if (out_valid !== vp[2]) begin
      n_bad++;
      $display("FAIL R10 out_valid actual=%b expected=%b", out_valid, vp[2]);
    end
    if (vp[2] && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (out_data !== e) begin
        n_bad++;
        $display("FAIL %s out_data actual=%h expected=%h", t, out_data, e);
      end
    end
  endtask

  task automatic step(input bit v, input logic [15:0] x,
                      input bit cwe, input logic [7:0] cb,
                      input bit kwe, input logic [1:0] ks, input logic [15:0] kd);
    @(negedge clk);
    check_out();
    vp = {vp[1:0], v};
    if (v) begin
      exp_q.push_back(ref_out(x));
      tag_q.push_back(cur_tag);
    end
    if (cwe) ctrl_m = {cb[7:1], 1'b0};
    if (kwe) cm[ks] = kd;
    in_valid   = v;
    in_data    = x;
    ctrl_we    = cwe;
    ctrl_wdata = cb;
    coef_we    = kwe;
    coef_sel   = ks;
    coef_data  = kd;
  endtask

  task automatic send(input logic [15:0] x);
    step(1'b1, x, 1'b0, 8'h00, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 8'h00, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic drain();
    repeat (4) idle();
  endtask

  task automatic wr_ctrl(input logic [7:0] b);
    step(1'b0, 16'h0, 1'b1, b, 1'b0, 2'd0, 16'h0);
    idle();
  endtask

  task automatic wr_coef(input logic [1:0] s, input logic [15:0] d);
    step(1'b0, 16'h0, 1'b0, 8'h00, 1'b1, s, d);
    idle();
  endtask

  task automatic chk_ctrl(input logic [7:0] e, input string t);
    n_vec++;
    if (ctrl_rdata !== e) begin
      n_bad++;
      $display("FAIL %s ctrl_rdata actual=%h expected=%h", t, ctrl_rdata, e);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    cm[0] = 16'h0000; cm[1] = 16'h8000; cm[2] = 16'h0000; cm[3] = 16'h8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and pass-through
    chk_ctrl(8'h1E, "R1");
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 out_valid actual=%b expected=0", out_valid);
    end
    cur_tag = "R1";
    send(16'h7FFF); send(16'h8000); send(16'h0000);
    for (int i = 0; i < 20; i++) send(16'($urandom()));
    drain();

    // R2, R3: field readback and reserved bit
    wr_ctrl(8'hFF); chk_ctrl(8'hFE, "R3");
    wr_ctrl(8'hA5); chk_ctrl(8'hA4, "R2");
    wr_ctrl(8'h01); chk_ctrl(8'h00, "R3");
    wr_ctrl(8'h1F); chk_ctrl(8'h1E, "R3");

    // R6, R4: coefficients in fixed order
    wr_coef(2'd0, 16'h0100);
    wr_coef(2'd1, 16'h9000);
    wr_coef(2'd2, 16'hFF80);
    wr_coef(2'd3, 16'h7000);
    wr_ctrl(8'h00); chk_ctrl(8'h00, "R2");
    cur_tag = "R4";
    send(16'h0000); send(16'hFFFF); send(16'h1234); send(16'hC000);
    for (int i = 0; i < 64; i++) send(16'($urandom()));
    drain();

    // R5: every bypass combination
    cur_tag = "R5";
    for (int d = 0; d < 16; d++) begin
      wr_ctrl(8'(d << 1));
      for (int i = 0; i < 16; i++) send(16'($urandom()));
      drain();
    end

    // R7: power-of-two gain after calibration
    cur_tag = "R7";
    for (int c = 0; c < 8; c++) begin
      wr_ctrl(8'((c << 5) | 8'h1E));
      send(16'h0001); send(16'hFFFF);
      for (int i = 0; i < 12; i++) send(16'(int'($urandom_range(0, 511)) - 256));
      drain();
      wr_ctrl(8'((c << 5) | 8'h00));
      for (int i = 0; i < 8; i++) send(16'(int'($urandom_range(0, 511)) - 256));
      drain();
    end

    // R8: bipolar clipping
    cur_tag = "R8";
    wr_ctrl(8'hFE);
    send(16'h7FFF); send(16'h8000); send(16'h0100); send(16'hFF00); send(16'h0000);
    for (int i = 0; i < 24; i++) send(16'($urandom()));
    drain();
    wr_coef(2'd1, 16'hFFFF);
    wr_coef(2'd0, 16'h8000);
    wr_ctrl(8'h18);
    send(16'h7FFF); send(16'h8000); send(16'h0000);
    for (int i = 0; i < 16; i++) send(16'($urandom()));
    drain();

    // R9: unipolar clipping
    cur_tag = "R9";
    bip = 1'b0;
    wr_coef(2'd0, 16'h0100);
    wr_coef(2'd1, 16'h9000);
    wr_ctrl(8'h00);
    send(16'h0000); send(16'h0050); send(16'hFFFF); send(16'hF000);
    for (int i = 0; i < 24; i++) send(16'($urandom()));
    drain();
    wr_ctrl(8'h7E);
    for (int i = 0; i < 24; i++) send(16'($urandom()));
    drain();
    wr_ctrl(8'h60);
    for (int i = 0; i < 24; i++) send(16'($urandom()));
    drain();

    // R10: streaming with gaps, both modes
    cur_tag = "R10";
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) != 0) send(16'($urandom()));
      else idle();
    end
    drain();
    bip = 1'b1;
    wr_ctrl(8'h20);
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 2) != 0) send(16'($urandom()));
      else idle();
    end
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule